// File: doc/BRIEF.md
# Zero-Suppressing Macropixel Readout Controller

This controller sits at the edge of a binary hit pixel array, 128 columns by 32 rows by default. The array is split into 4x4 macropixels. Each macropixel raises a private hit flag toward the controller. When a flag arrives, the controller marks that macropixel as pending and stores the free-running timestamp value for it.

Pending macropixels are then served one at a time. For each one, the controller enables it onto a shared 16-bit data bus. It emits one formatted word for every set pixel on that bus, and pixels that are not set produce nothing. When every set pixel has been written, it pulses a clear strobe back to the array. The words go into a small output buffer, which is drained through a valid/ready handshake.

Top module: `mpx_readout`

## Requirements
- R1: A synchronous reset empties the buffer (`out_valid`=0, `busy`=0), drops every pending macropixel so no word from before reset is ever emitted, releases the bus (`rd_en`=0), and sets the timestamp counter to 0.
- R2: Each output word is {bit top = 0, timestamp (TSW bits), absolute column, absolute row}. The column is macrocolumn*4 + local column. The row is macrorow*4 + local row. Macropixel index i has macrocolumn i mod (NCOL/4) and macrorow i div (NCOL/4). Data bus bit b has local column b[1:0] and local row b[3:2].
- R3: The timestamp counter advances by one on each cycle with `tick` high, and wraps from 2^TSW-1 to 0.
- R4: A macropixel takes the timestamp value present in the cycle its hit flag is first seen. A further hit while it is still pending keeps that first timestamp, and its new pixels are emitted with it.
- R5: Pending macropixels are served in ascending index order, whatever order their hits arrived in. Within a macropixel, pixels are emitted in ascending bus bit order.
- R6: Exactly one macropixel is enabled at a time (`rd_en`, `rd_sel`). It stays enabled until all of its set pixels have been written, and then `rd_clr` pulses for one cycle.
- R7: Every set pixel gives exactly one word, and a macropixel with no set pixels gives none.
- R8: When the buffer holds DEPTH words, `busy` is high and the scan stalls with no word lost. Words leave on cycles where both `out_valid` and `out_ready` are high, and the head word holds steady while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timestamp advance strobe |
| mp_hit | input | NMP | Private hit flag per macropixel |
| rd_en | output | 1 | A macropixel is enabled onto the shared bus |
| rd_sel | output | MPW | Index of the enabled macropixel |
| rd_data | input | 16 | Shared pixel bus from the enabled macropixel |
| rd_clr | output | 1 | Clear strobe for the enabled macropixel's pixel latches |
| out_valid | output | 1 | Buffer head holds a word |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | W | Formatted hit word |
| busy | output | 1 | Buffer full |

## Verification
The bench builds the controller with an 8x8 array and a 4-entry buffer. This gives four macropixels and 64 pixels, so each pixel can be hit alone and its word checked against coordinates computed in the bench. The small buffer fills after four words. That makes the stall, the held bus enable and re-hits during a stall easy to reach, together with an ordering check where hits arrive out of index order. A 255-tick run reaches the timestamp wrap, and a reset taken with words still buffered shows that nothing from before the reset is ever emitted.

// File: rtl/mpx_readout.sv
module mpx_readout #(
  parameter int NCOL  = 128,
  parameter int NROW  = 32,
  parameter int TSW   = 8,
  parameter int DEPTH = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              tick,
  input  logic [(NCOL/4)*(NROW/4)-1:0]      mp_hit,
  output logic                              rd_en,
  output logic [$clog2((NCOL/4)*(NROW/4))-1:0] rd_sel,
  input  logic [15:0]                       rd_data,
  output logic                              rd_clr,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [TSW+$clog2(NCOL)+$clog2(NROW):0] out_data,
  output logic                              busy
);
  localparam int NMC  = NCOL / 4;
  localparam int NMP  = NMC * (NROW / 4);
  localparam int MPW  = $clog2(NMP);
  localparam int MCW  = $clog2(NMC);
  localparam int CW   = $clog2(NCOL);
  localparam int RW   = $clog2(NROW);
  localparam int W    = 1 + TSW + CW + RW;
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;

  logic [TSW-1:0] ts_cnt;
  logic [NMP-1:0] pending;
  logic [TSW-1:0] ts_mem [NMP];
  logic           active;
  logic [MPW-1:0] sel, nxt;
  logic [15:0]    done, rem;
  logic [3:0]     lb;
  logic           wr, fin, full;
  logic [W-1:0]   mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CNTW-1:0] cnt;
  logic [TSW-1:0] cur_ts;

  always_ff @(posedge clk)
    if (rst) ts_cnt <= '0;
    else if (tick) ts_cnt <= ts_cnt + 1'b1;

  always_comb begin
    nxt = '0;
    for (int i = NMP - 1; i >= 0; i--)
      if (pending[i]) nxt = MPW'(i);
  end

  assign rem = rd_data & ~done;

  always_comb begin
    lb = '0;
    for (int b = 15; b >= 0; b--)
      if (rem[b]) lb = 4'(b);
  end

  assign full   = cnt == CNTW'(DEPTH);
  assign wr     = active && (|rem) && !full;
  assign fin    = active && !(|rem);
  assign cur_ts = ts_mem[sel];

  always_ff @(posedge clk)
    if (rst) begin
      pending <= '0;
      for (int i = 0; i < NMP; i++) ts_mem[i] <= '0;
    end else begin
      for (int i = 0; i < NMP; i++) begin
        if (fin && sel == MPW'(i)) begin
          pending[i] <= mp_hit[i];
          if (mp_hit[i]) ts_mem[i] <= ts_cnt;
        end else if (mp_hit[i] && !pending[i]) begin
          pending[i] <= 1'b1;
          ts_mem[i]  <= ts_cnt;
        end
      end
    end

  always_ff @(posedge clk)
    if (rst) begin
      active <= 1'b0;
      sel    <= '0;
      done   <= '0;
    end else if (!active) begin
      if (|pending) begin
        active <= 1'b1;
        sel    <= nxt;
        done   <= '0;
      end
    end else if (fin) begin
      active <= 1'b0;
    end else if (wr) begin
      done <= done | (16'd1 << lb);
    end

  assign rd_en  = active;
  assign rd_sel = sel;
  assign rd_clr = fin;

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {1'b0, cur_ts, sel[MCW-1:0], lb[1:0], sel[MPW-1:MCW], lb[3:2]};

  always_ff @(posedge clk)
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (out_valid && out_ready) rp <= rp + 1'b1;
      cnt <= cnt + CNTW'(wr) - CNTW'(out_valid && out_ready);
    end

  assign out_valid = cnt != '0;
  assign out_data  = mem[rp];
  assign busy      = full;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH));
  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !out_ready |=> busy);
  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_clr |=> rd_en && $stable(rd_sel));
  // R4
  ts_keep_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_clr |=> $stable(cur_ts));
endmodule

// File: tb/mpx_readout_tb.sv
module mpx_readout_tb;
  localparam int P = 10;
  localparam int NMP = 4;
  localparam int W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [NMP-1:0] mp_hit = '0;
  logic rd_en, rd_clr, out_valid, busy;
  logic [1:0] rd_sel;
  logic [15:0] rd_data;
  logic out_ready = 1'b1;
  logic [W-1:0] out_data;

  logic [15:0] pix [NMP];
  logic [15:0] newb [NMP];
  logic [W-1:0] got [128];
  logic [W-1:0] exp_w [128];
  int gn = 0, en = 0, total = 0, bad = 0;
  int ts_m = 0;

  always #(P/2) clk = ~clk;

  mpx_readout #(.NCOL(8), .NROW(8), .TSW(8), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .mp_hit(mp_hit),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_clr(rd_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy));

  assign rd_data = rd_en ? pix[rd_sel] : 16'd0;

  initial for (int i = 0; i < NMP; i++) begin pix[i] = '0; newb[i] = '0; end

  always @(posedge clk)
    for (int i = 0; i < NMP; i++)
      if (rst) pix[i] <= '0;
      else pix[i] <= ((rd_clr && rd_sel == 2'(i)) ? 16'd0 : pix[i]) | newb[i];

  always @(negedge clk)
    if (!rst && out_valid && out_ready) begin
      if (gn < 128) got[gn] = out_data;
      gn++;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  function automatic logic [W-1:0] mkword(input int ts, input int mp, input int b);
    int col, row;
    col = (mp % 2) * 4 + b % 4;
    row = (mp / 2) * 4 + b / 4;
    return {1'b0, 8'(ts), 3'(col), 3'(row)};
  endfunction

  task automatic expect_bits(input int mp, input logic [15:0] bits, input int ts);
    for (int b = 0; b < 16; b++)
      if (bits[b]) begin exp_w[en] = mkword(ts, mp, b); en++; end
  endtask

  task automatic hit(input logic [NMP-1:0] m, input logic [15:0] b0, input logic [15:0] b1,
                     input logic [15:0] b2, input logic [15:0] b3);
    newb[0] = b0; newb[1] = b1; newb[2] = b2; newb[3] = b3;
    mp_hit = m;
    step();
    for (int i = 0; i < NMP; i++) newb[i] = '0;
    mp_hit = '0;
  endtask

  task automatic hit1(input int mp, input logic [15:0] bits);
    logic [15:0] z [NMP];
    for (int i = 0; i < NMP; i++) z[i] = (i == mp) ? bits : 16'd0;
    hit(4'(1 << mp), z[0], z[1], z[2], z[3]);
  endtask

  task automatic tick_n(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
    ts_m = (ts_m + n) % 256;
  endtask

  task automatic clear_lists(); gn = 0; en = 0; endtask

  task automatic drain(input string tag);
    int k;
    out_ready = 1'b1;
    k = 0;
    while (gn < en && k < 200) begin step(); k++; end
    repeat (6) step();
    chk(gn == en, {tag, " count"}, gn, en);
    for (int i = 0; i < en && i < gn; i++)
      chk(got[i] == exp_w[i], tag, int'(got[i]), int'(exp_w[i]));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    ts_m = 0;
  endtask

  initial begin
    #(P * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rd_en == 0, "R1 rd_en", rd_en, 0);

    // R2 R7: every pixel alone, timestamp moving between hits
    for (int mp = 0; mp < NMP; mp++)
      for (int b = 0; b < 16; b++) begin
        clear_lists();
        expect_bits(mp, 16'd1 << b, ts_m);
        hit1(mp, 16'd1 << b);
        drain("R2 single pixel word");
        tick_n(1 + b);
      end

    // R5 R7: several macropixels at once, one with no pixels
    clear_lists();
    expect_bits(0, 16'h8001, ts_m);
    expect_bits(2, 16'hFFFF, ts_m);
    expect_bits(3, 16'h0660, ts_m);
    hit(4'b1101, 16'h8001, 16'h0000, 16'hFFFF, 16'h0660);
    drain("R5 multi macropixel order");

    // R8 R4 R5 R6: stall, re-hits, out-of-order arrival
    clear_lists();
    out_ready = 1'b0;
    begin
      int a;
      a = ts_m;
      expect_bits(0, 16'h80FF, a);
      expect_bits(1, 16'h0060, a + 2);
      expect_bits(2, 16'h0008, a + 1);
      hit1(0, 16'h00FF);
      repeat (20) step();
      chk(busy == 1, "R8 busy when full", busy, 1);
      chk(out_valid == 1, "R8 valid when full", out_valid, 1);
      chk(rd_en == 1 && rd_sel == 0, "R6 bus held on stalled macropixel", rd_sel, 0);
      hit1(0, 16'h8000);
      tick_n(1);
      hit1(2, 16'h0008);
      tick_n(1);
      hit1(1, 16'h0020);
      tick_n(1);
      hit1(1, 16'h0040);
      repeat (10) step();
      chk(gn == 0, "R8 no output while not ready", gn, 0);
      drain("R4 R5 R8 stalled sequence");
      chk(busy == 0, "R8 busy cleared", busy, 0);
    end

    // R3 wrap
    do_reset();
    clear_lists();
    tick_n(255);
    expect_bits(1, 16'h0001, 255);
    hit1(1, 16'h0001);
    tick_n(1);
    expect_bits(1, 16'h0002, 0);
    repeat (30) step();
    hit1(1, 16'h0002);
    drain("R3 timestamp wrap");

    // R1 reset with buffered and pending data
    clear_lists();
    out_ready = 1'b0;
    tick_n(7);
    hit(4'b1001, 16'h0001, 16'h0000, 16'h0000, 16'h000F);
    repeat (10) step();
    do_reset();
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(rd_en == 0, "R1 rd_en after reset", rd_en, 0);
    out_ready = 1'b1;
    repeat (20) step();
    chk(gn == 0, "R1 nothing left after reset", gn, 0);
    clear_lists();
    expect_bits(0, 16'h0001, 0);
    hit1(0, 16'h0001);
    drain("R1 timestamp cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule